// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller for a UART Channel

This block runs hardware flow control for a single UART channel. On the receive side it compares the receive FIFO fill count against one of four selectable trigger levels. It raises a receive interrupt at the chosen level. It drives the RTS line inactive when the FIFO climbs to a higher mark, and drives it active again only once the FIFO has drained to a lower mark. The gap between the two marks keeps RTS from toggling on every character. Characters are still accepted while RTS is inactive, until the FIFO is completely full.

On the transmit side it synchronizes the remote CTS input and gates the transmitter through `tx_allow`. If the transmitter is in the middle of a character when CTS goes inactive, that character finishes through its stop bit before transmission halts. A rising CTS can also latch an interrupt flag, which a status read clears. Auto RTS and auto CTS each have their own enable. With auto RTS off, the RTS pin follows a software level.

The block carries no data stream, so every pin is a plain level or strobe with no valid/ready handshake. The FIFO storage and the serial shifters sit outside it.

Top module: `uart_flow_ctl`

## Requirements
- R1: `trig_sel` encodes the receive trigger level as 0→8, 1→16, 2→56, 3→60 characters. `rx_irq` is high one clock after `rx_count` is at or above the selected level, and low one clock after it falls below it.
- R2: With `auto_rts_en`=1, `rts_n` goes to 1 one clock after `rx_count` reaches the upper mark: 16, 56, 60, 60 for `trig_sel` 0, 1, 2, 3.
- R3: With `auto_rts_en`=1, `rts_n` returns to 0 one clock after `rx_count` falls to or below the lower mark: 0, 8, 16, 56 for `trig_sel` 0, 1, 2, 3. Strictly between the marks, `rts_n` holds its value.
- R4: `rx_accept` is 1 whenever `rx_count` is below 64 (FIFO not full), independent of `rts_n`, and 0 at 64.
- R5: With `auto_rts_en`=0, `rts_n` equals `sw_rts_n` in the same cycle, and `rx_count` has no effect on it.
- R6: `cts_n` passes through a two-flop synchronizer. A change on `cts_n` reaches `cts_irq` and `tx_allow` on the third rising clock edge after it.
- R7: `cts_irq` stays set until `status_rd` is 1 at a clock edge. If a new CTS rise and `status_rd` coincide, the flag stays set.
- R8: With `auto_cts_en`=1 and the synchronized `cts_n`=1:
  - `tx_allow` drops at the next edge if `tx_active`=0.
  - If `tx_active`=1, `tx_allow` stays 1 until the edge at which `tx_char_end` is sampled high, and then goes to 0.
- R9: `tx_allow` is 1 one clock after the synchronized `cts_n` is 0 or `auto_cts_en` is 0. Its value after reset is 1.
- R10: A 0→1 change of the synchronized `cts_n` sets `cts_irq` only when `cts_irq_en`=1. Otherwise the flag is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | CNT_W (7) | Receive FIFO fill count, 0..64 |
| trig_sel | input | 2 | Trigger level select (R1 encoding) |
| auto_rts_en | input | 1 | Enable automatic RTS |
| sw_rts_n | input | 1 | Software RTS level used when automatic RTS is off |
| auto_cts_en | input | 1 | Enable automatic CTS gating |
| cts_irq_en | input | 1 | Enable for the CTS interrupt flag |
| cts_n | input | 1 | Remote CTS, asynchronous, 1 = stop sending |
| tx_active | input | 1 | Transmitter is shifting a character |
| tx_char_end | input | 1 | Strobe: stop bit of the current character finished |
| status_rd | input | 1 | Strobe: clears the CTS interrupt flag |
| rts_n | output | 1 | RTS to the remote end, 1 = inactive |
| rx_irq | output | 1 | Receive trigger-level interrupt |
| rx_accept | output | 1 | Receiver may still store characters |
| tx_allow | output | 1 | Transmitter may start or continue a character |
| cts_irq | output | 1 | Latched CTS-rise interrupt flag |

## Verification
The bench steps every trigger selection up and down through its two marks and checks the hold band. A design with a single threshold would release RTS one character below the upper mark rather than at the lower mark. It also checks the full-FIFO boundary, where a design that tied acceptance to RTS would drop characters. On the CTS side it raises CTS with a character in flight and with the transmitter idle. A design that cut `tx_allow` at once would truncate a character, and one that waited for a strobe that never comes would leave an idle transmitter free to start. It also clears the flag with a read on the same edge as a new rise, which a clear-wins design would lose.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    TRIG_8  = 2'd0,
    TRIG_16 = 2'd1,
    TRIG_56 = 2'd2,
    TRIG_60 = 2'd3
  } trig_sel_e;

  typedef struct packed {
    int unsigned fire;  // receive interrupt level
    int unsigned off;   // RTS goes inactive at or above
    int unsigned on;    // RTS goes active at or below
  } thresh_t;

  // Marks derived from FIFO depth so a deeper FIFO scales the top levels.
  function automatic thresh_t lookup_thresh(trig_sel_e sel, int unsigned depth);
    thresh_t t;
    case (sel)
      TRIG_8:  begin t.fire = 8;         t.off = 16;        t.on = 0;         end
      TRIG_16: begin t.fire = 16;        t.off = depth - 8; t.on = 8;         end
      TRIG_56: begin t.fire = depth - 8; t.off = depth - 4; t.on = 16;        end
      default: begin t.fire = depth - 4; t.off = depth - 4; t.on = depth - 8; end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain[0] |=> (STAGES == 1 ? q : chain[(STAGES > 1) ? 1 : 0]));
endmodule

// File: rtl/fc_rts_ctl.sv
module fc_rts_ctl
  import fc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  trig_sel_e        sel,
  input  logic             auto_en,
  input  logic             sw_rts_n,
  output logic             rts_n,
  output logic             rx_irq,
  output logic             rx_accept
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  thresh_t          th;
  logic [CNT_W-1:0] fire_lvl, off_lvl, on_lvl;
  logic             rts_off;

  always_comb begin
    th       = lookup_thresh(sel, DEPTH);
    fire_lvl = CNT_W'(th.fire);
    off_lvl  = CNT_W'(th.off);
    on_lvl   = CNT_W'(th.on);
  end

  // Hysteresis state: raise at the upper mark, drop at the lower mark.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rts_off <= 1'b0;
    else if (!auto_en)          rts_off <= 1'b0;
    else if (count >= off_lvl)  rts_off <= 1'b1;
    else if (count <= on_lvl)   rts_off <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= (count >= fire_lvl);
  end

  assign rts_n     = auto_en ? rts_off : sw_rts_n;
  assign rx_accept = (count < FULL);

  // R2
  rts_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && count >= off_lvl) |=> rts_n);
  // R3
  rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && count <= on_lvl && count < off_lvl) |=> (auto_en -> !rts_n));
  // R3
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && count > on_lvl && count < off_lvl) |=> (rts_off == $past(rts_off)));
  // R1
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(count >= fire_lvl));
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_s,
  input  logic auto_en,
  input  logic irq_en,
  input  logic tx_active,
  input  logic tx_char_end,
  input  logic status_rd,
  output logic tx_allow,
  output logic cts_irq
);
  logic cts_d;
  logic cts_rise;
  logic pause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_d <= 1'b0;
    else        cts_d <= cts_s;
  end

  assign cts_rise = cts_s && !cts_d;
  assign pause    = auto_en && cts_s;

  // A new rise takes priority over a clearing read on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cts_irq <= 1'b0;
    else if (cts_rise && irq_en) cts_irq <= 1'b1;
    else if (status_rd)          cts_irq <= 1'b0;
  end

  // Let a character in flight finish its stop bit before pausing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tx_allow <= 1'b1;
    else if (!pause)                     tx_allow <= 1'b1;
    else if (!tx_active || tx_char_end)  tx_allow <= 1'b0;
  end

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_irq && !status_rd) |=> cts_irq);
  // R10
  flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_irq && !irq_en) |=> !cts_irq);
  // R8
  no_cut_mid_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_allow) |-> $past(!tx_active || tx_char_end));
  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en || !cts_s) |=> tx_allow);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import fc_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [1:0]       trig_sel,
  input  logic             auto_rts_en,
  input  logic             sw_rts_n,
  input  logic             auto_cts_en,
  input  logic             cts_irq_en,
  input  logic             cts_n,
  input  logic             tx_active,
  input  logic             tx_char_end,
  input  logic             status_rd,
  output logic             rts_n,
  output logic             rx_irq,
  output logic             rx_accept,
  output logic             tx_allow,
  output logic             cts_irq
);
  logic cts_s;

  fc_rts_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_rts (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (rx_count),
    .sel       (trig_sel_e'(trig_sel)),
    .auto_en   (auto_rts_en),
    .sw_rts_n  (sw_rts_n),
    .rts_n     (rts_n),
    .rx_irq    (rx_irq),
    .rx_accept (rx_accept)
  );

  fc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cts_n),
    .q     (cts_s)
  );

  fc_cts_gate i_cts (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_s       (cts_s),
    .auto_en     (auto_cts_en),
    .irq_en      (cts_irq_en),
    .tx_active   (tx_active),
    .tx_char_end (tx_char_end),
    .status_rd   (status_rd),
    .tx_allow    (tx_allow),
    .cts_irq     (cts_irq)
  );
endmodule

// File: tb/test_uart_flow_ctl.sv
module test_uart_flow_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rx_count = '0;
  logic [1:0] trig_sel = '0;
  logic auto_rts_en = 0, sw_rts_n = 1, auto_cts_en = 0, cts_irq_en = 0;
  logic cts_n = 0, tx_active = 0, tx_char_end = 0, status_rd = 0;
  logic rts_n, rx_irq, rx_accept, tx_allow, cts_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_flow_ctl i_uart_flow_ctl (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .sw_rts_n(sw_rts_n), .auto_cts_en(auto_cts_en),
    .cts_irq_en(cts_irq_en), .cts_n(cts_n), .tx_active(tx_active),
    .tx_char_end(tx_char_end), .status_rd(status_rd), .rts_n(rts_n),
    .rx_irq(rx_irq), .rx_accept(rx_accept), .tx_allow(tx_allow), .cts_irq(cts_irq)
  );

  // {trig_sel, rx_count, exp rts_n, exp rx_irq, exp rx_accept}
  localparam int NV = 22;
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 7'd0,  1'b0, 1'b0, 1'b1},
    {2'd0, 7'd7,  1'b0, 1'b0, 1'b1},
    {2'd0, 7'd8,  1'b0, 1'b1, 1'b1},
    {2'd0, 7'd15, 1'b0, 1'b1, 1'b1},
    {2'd0, 7'd16, 1'b1, 1'b1, 1'b1},
    {2'd0, 7'd10, 1'b1, 1'b1, 1'b1},
    {2'd0, 7'd7,  1'b1, 1'b0, 1'b1},
    {2'd0, 7'd1,  1'b1, 1'b0, 1'b1},
    {2'd0, 7'd0,  1'b0, 1'b0, 1'b1},
    {2'd1, 7'd20, 1'b0, 1'b1, 1'b1},
    {2'd1, 7'd56, 1'b1, 1'b1, 1'b1},
    {2'd1, 7'd30, 1'b1, 1'b1, 1'b1},
    {2'd1, 7'd9,  1'b1, 1'b0, 1'b1},
    {2'd1, 7'd8,  1'b0, 1'b0, 1'b1},
    {2'd2, 7'd57, 1'b0, 1'b1, 1'b1},
    {2'd2, 7'd60, 1'b1, 1'b1, 1'b1},
    {2'd2, 7'd17, 1'b1, 1'b0, 1'b1},
    {2'd2, 7'd16, 1'b0, 1'b0, 1'b1},
    {2'd3, 7'd59, 1'b0, 1'b0, 1'b1},
    {2'd3, 7'd60, 1'b1, 1'b1, 1'b1},
    {2'd3, 7'd64, 1'b1, 1'b1, 1'b0},
    {2'd3, 7'd56, 1'b0, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // Reset state
    check("R5 reset rts_n follows sw", rts_n, 1'b1);
    check("R1 reset rx_irq", rx_irq, 1'b0);
    check("R9 reset tx_allow", tx_allow, 1'b1);
    check("R7 reset cts_irq", cts_irq, 1'b0);

    // R5: software RTS, count ignored
    sw_rts_n = 1'b0; rx_count = 7'd60; trig_sel = 2'd0;
    tick(1);
    check("R5 sw low with count 60", rts_n, 1'b0);
    sw_rts_n = 1'b1;
    #1;
    check("R5 sw high same cycle", rts_n, 1'b1);

    // Table walk with auto RTS on
    rx_count = 7'd0; auto_rts_en = 1'b1;
    tick(1);
    for (int i = 0; i < NV; i++) begin
      trig_sel = VEC[i][11:10];
      rx_count = VEC[i][9:3];
      tick(1);
      check($sformatf("R2/R3 rts_n vec %0d", i), rts_n, VEC[i][2]);
      check($sformatf("R1 rx_irq vec %0d", i), rx_irq, VEC[i][1]);
      check($sformatf("R4 rx_accept vec %0d", i), rx_accept, VEC[i][0]);
    end
    auto_rts_en = 1'b0;
    rx_count = 7'd0;

    // R6/R8: CTS rises with a character in flight
    auto_cts_en = 1'b1; cts_irq_en = 1'b1; tx_active = 1'b1; cts_n = 1'b1;
    tick(2);
    check("R6 flag not yet after two edges", cts_irq, 1'b0);
    tick(1);
    check("R6 flag on third edge", cts_irq, 1'b1);
    check("R8 tx_allow held mid character", tx_allow, 1'b1);
    tick(3);
    check("R8 still held until stop bit", tx_allow, 1'b1);
    tx_char_end = 1'b1;
    tick(1);
    check("R8 pause after stop bit", tx_allow, 1'b0);
    tx_char_end = 1'b0; tx_active = 1'b0;
    tick(2);
    check("R7 flag persists", cts_irq, 1'b1);
    status_rd = 1'b1;
    tick(1);
    check("R7 flag cleared by read", cts_irq, 1'b0);
    status_rd = 1'b0;

    // R9: CTS returns
    cts_n = 1'b0;
    tick(2);
    check("R6 tx_allow not yet resumed", tx_allow, 1'b0);
    tick(1);
    check("R9 resume after CTS low", tx_allow, 1'b1);

    // R8 idle / R10 masked flag
    cts_irq_en = 1'b0; cts_n = 1'b1;
    tick(3);
    check("R8 idle pause", tx_allow, 1'b0);
    check("R10 masked flag stays clear", cts_irq, 1'b0);
    auto_cts_en = 1'b0;
    tick(1);
    check("R9 auto CTS disabled resumes", tx_allow, 1'b1);
    cts_n = 1'b0;
    tick(3);

    // R7: set wins over a coincident read
    cts_irq_en = 1'b1; cts_n = 1'b1;
    tick(2);
    status_rd = 1'b1;
    tick(1);
    check("R7 set wins over read", cts_irq, 1'b1);
    status_rd = 1'b0;
    cts_n = 1'b0;
    tick(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule